// File: doc/BRIEF.md
# Parallel Bit Deposit and Extract Unit

This unit performs the two mask-driven bit permutations on a word whose width is a parameter (32 or 64 bits). In deposit mode the low-order bits of the source word are scattered, in order, to the bit positions that are set in the mask. In extract mode the source bits found at the set mask positions are gathered into a packed field at the low end of the result. Result positions that the operation does not write are zero.

The unit is sequential and uses a start/done handshake. A pulse on `start` while the unit is idle captures the mode, source and mask. The unit then walks the captured mask from its lowest set bit upward. Each cycle, a priority encoder finds the trailing set bit, one result bit is written, and that mask bit is cleared with mask AND (mask minus one). When no set bit remains, `done` pulses for one cycle. The result then holds until the next accepted start. The latency therefore tracks the population count of the mask, so sparse masks finish early.

Top module: `pdx_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: With `mode` = 0 (deposit), source bit k ends up at the bit position of the k-th set mask bit, counting set bits from bit 0 upward with the first one as k = 0.
- R3: With `mode` = 1 (extract), the source bit at the position of the k-th set mask bit ends up as result bit k.
- R4: Every result bit that the operation does not write is 0, so an all-zero mask gives a zero result in either mode.
- R5: With the start edge counted as cycle 0, `done` is high in the cycle after clock edge number popcount(mask)+1. It is high for exactly one cycle.
- R6: A `start` pulse while `busy` is 1 is ignored. The running operation finishes with its own source, mask and mode, and with its own latency.
- R7: While the unit is idle and `start` is low, `result` does not change, whatever the values on `src`, `mask` and `mode`.
- R8: An all-ones mask makes both deposit and extract return the source word unchanged.
- R9: A `start` presented in the same cycle that `done` is high is accepted. The new operation runs with the normal latency and gives its own correct result.
- R10: Mask bits are consumed lowest first, one per cycle. During a walk, at most one bit of `result` changes from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request; takes effect only while idle |
| mode | input | 1 | 0 = deposit, 1 = extract |
| src | input | WIDTH | Source word |
| mask | input | WIDTH | Selection mask |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Permuted word; valid from `done` until the next accepted start |

## Verification
Two things can land in the same cycle: the completion pulse of one operation and the launch of the next. The bench drives `start`, with a fresh operand set, during the very cycle that `done` is observed high. It then checks that the second operation's latency is exactly its mask population count plus one, and that its result matches the bench's own reference model with no trace of the first result. A related overlap is also tested: a launch request that arrives mid-walk must leave the running walk's result and latency untouched.

// File: rtl/pdx_pkg.sv
// Shared types for the bit deposit/extract unit.
// Assumes: nothing beyond IEEE 1800-2017.
package pdx_pkg;
    typedef enum logic {
        OP_DEPOSIT = 1'b0,
        OP_EXTRACT = 1'b1
    } pdx_op_e;
endpackage

// File: rtl/pdx_trail_locator.sv
// Priority encoder returning the index of the lowest set bit of vec.
// Assumes: idx is meaningless when any is 0.
module pdx_trail_locator #(
    parameter int WIDTH = 64,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IW-1:0]    idx,
    output logic             any
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // Flag that at least one bit remains.
    assign any = |vec;
endmodule

// File: rtl/pdx_step.sv
// One walk step: clears the trailing mask bit and moves one data bit.
// Assumes: pos is the trailing set bit of rem_mask; k is the walk count.
module pdx_step
    import pdx_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int IW = $clog2(WIDTH)
) (
    input  pdx_op_e          op,
    input  logic [WIDTH-1:0] src_word,
    input  logic [WIDTH-1:0] rem_mask,
    input  logic [WIDTH-1:0] cur_result,
    input  logic [IW-1:0]    pos,
    input  logic [IW-1:0]    k,
    output logic [WIDTH-1:0] nxt_mask,
    output logic [WIDTH-1:0] nxt_result
);
    // Drop the lowest set bit of the remaining mask.
    assign nxt_mask = rem_mask & (rem_mask - WIDTH'(1));

    // Route a single bit according to the operation.
    always_comb begin
        if (op == OP_DEPOSIT)
            nxt_result = cur_result | (WIDTH'(src_word[k]) << pos);
        else
            nxt_result = cur_result | (WIDTH'(src_word[pos]) << k);
    end
endmodule

// File: rtl/pdx_unit.sv
// Sequential parallel bit deposit/extract unit.
// One set mask bit is handled per cycle, lowest first, and done pulses
// one cycle after the mask is exhausted.
// Assumes: start is sampled only while idle; WIDTH is 32 or 64.
module pdx_unit
    import pdx_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] mask,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int IW = $clog2(WIDTH);

    pdx_op_e          op_q;
    logic [WIDTH-1:0] src_q;
    logic [WIDTH-1:0] rem_q;
    logic [IW-1:0]    k_q;
    logic [IW-1:0]    loc_idx;
    logic             loc_any;
    logic [WIDTH-1:0] step_mask;
    logic [WIDTH-1:0] step_result;

    pdx_trail_locator #(.WIDTH(WIDTH)) u_loc (
        .vec (rem_q),
        .idx (loc_idx),
        .any (loc_any)
    );

    pdx_step #(.WIDTH(WIDTH)) u_step (
        .op         (op_q),
        .src_word   (src_q),
        .rem_mask   (rem_q),
        .cur_result (result),
        .pos        (loc_idx),
        .k          (k_q),
        .nxt_mask   (step_mask),
        .nxt_result (step_result)
    );

    // Capture on launch, step while bits remain, then finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
            op_q   <= OP_DEPOSIT;
            src_q  <= '0;
            rem_q  <= '0;
            k_q    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    op_q   <= pdx_op_e'(mode);
                    src_q  <= src;
                    rem_q  <= mask;
                    result <= '0;
                    k_q    <= '0;
                end
            end else if (loc_any) begin
                rem_q  <= step_mask;
                result <= step_result;
                k_q    <= k_q + IW'(1);
            end else begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // R10: the locator points at the lowest remaining mask bit.
    p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && loc_any |-> rem_q[loc_idx] &&
            ((rem_q & ((WIDTH'(1) << loc_idx) - WIDTH'(1))) == '0));

    // R10: a walk changes at most one result bit per cycle.
    p_one_bit_per_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $countones(result ^ $past(result)) <= 1);

    // R5: done lasts a single cycle.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: an empty mask finishes two edges after launch with a zero result.
    p_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && mask == '0 |-> ##2 (done && result == '0));

    // R6: captured operands are frozen while walking.
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(src_q) && $stable(op_q));

    // R7: idle without start keeps the result.
    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(result));
endmodule

// File: tb/tb_pdx_unit.sv
`timescale 1ns/1ps
module tb_pdx_unit;
    localparam int W  = 64;
    localparam int NV = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] src = '0;
    logic [W-1:0] mask = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pdx_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .src(src), .mask(mask), .busy(busy), .done(done), .result(result)
    );

    localparam logic         V_MODE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [W-1:0] V_SRC  [NV] = '{
        64'h0000_0000_0000_00FF, 64'hDEAD_BEEF_CAFE_F00D,
        64'h0123_4567_89AB_CDEF, 64'hF0F0_F0F0_F0F0_F0F0,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001,
        64'h0000_0000_0000_0005, 64'hAAAA_5555_AAAA_5555};
    localparam logic [W-1:0] V_MASK [NV] = '{
        64'h0F0F_0F0F_0F0F_0F0F, 64'h00FF_0000_FF00_0F00,
        64'hAAAA_AAAA_AAAA_AAAA, 64'h8000_0000_0000_0001,
        64'h8000_0000_0000_0001, 64'hFFFF_0000_0000_FFFF,
        64'h0000_1000_0100_0010, 64'h5555_5555_0000_0000};

    // Reference model built from the requirement text.
    function automatic logic [W-1:0] ref_op(input logic m, input logic [W-1:0] s,
                                            input logic [W-1:0] k);
        logic [W-1:0] r = '0;
        int n = 0;
        for (int i = 0; i < W; i++) begin
            if (k[i]) begin
                if (!m) r[i] = s[n];
                else    r[n] = s[i];
                n++;
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drives a launch at the current negedge; returns at the negedge after it.
    task automatic launch(input logic m, input logic [W-1:0] s, input logic [W-1:0] k);
        mode = m; src = s; mask = k; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Counts edges until done is seen; records the largest per-cycle flip.
    task automatic wait_done(output int lat, output int maxflip);
        logic [W-1:0] prev;
        int f;
        prev = result; lat = 0; maxflip = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            f = $countones(result ^ prev);
            if (f > maxflip) maxflip = f;
            prev = result;
        end while (!done);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lat, mf;
        logic [W-1:0] held, exp;
        start = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        // R1 reset state
        check(busy == 1'b0 && done == 1'b0, "R1 busy/done", W'({busy, done}), '0);
        check(result == '0, "R1 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R5/R10 table walk
        for (int v = 0; v < NV; v++) begin
            exp = ref_op(V_MODE[v], V_SRC[v], V_MASK[v]);
            launch(V_MODE[v], V_SRC[v], V_MASK[v]);
            wait_done(lat, mf);
            check(result == exp, V_MODE[v] ? "R3 extract" : "R2 deposit", result, exp);
            check(lat == $countones(V_MASK[v]) + 1, "R5 latency", W'(lat),
                  W'($countones(V_MASK[v]) + 1));
            check(mf <= 1, "R10 one bit per cycle", W'(mf), W'(1));
            @(negedge clk);
            check(done == 1'b0, "R5 single-cycle done", W'(done), '0);
        end

        // R4 zero mask in both modes
        for (int m = 0; m < 2; m++) begin
            launch(m[0], 64'hFFFF_FFFF_FFFF_FFFF, '0);
            wait_done(lat, mf);
            check(result == '0, "R4 zero mask result", result, '0);
            check(lat == 1, "R4 zero mask latency", W'(lat), W'(1));
            @(negedge clk);
        end

        // R8 all-ones mask in both modes
        for (int m = 0; m < 2; m++) begin
            launch(m[0], 64'h1357_9BDF_2468_ACE0, '1);
            wait_done(lat, mf);
            check(result == 64'h1357_9BDF_2468_ACE0, "R8 identity", result,
                  64'h1357_9BDF_2468_ACE0);
            @(negedge clk);
        end

        // R6 start while busy is ignored
        launch(1'b0, 64'hC3C3_0000_FFFF_1234, '1);
        mode = 1'b1; src = 64'h1111; mask = '0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done(lat, mf);
        check(result == 64'hC3C3_0000_FFFF_1234, "R6 result kept", result,
              64'hC3C3_0000_FFFF_1234);
        check(lat + 1 == W + 1, "R6 latency kept", W'(lat + 1), W'(W + 1));

        // R9 start in the done cycle
        exp = ref_op(1'b1, 64'h0F1E_2D3C_4B5A_6978, 64'h00F0_0F00_F00F_0FF0);
        launch(1'b1, 64'h0F1E_2D3C_4B5A_6978, 64'h00F0_0F00_F00F_0FF0);
        wait_done(lat, mf);
        check(result == exp, "R9 back-to-back result", result, exp);
        check(lat == $countones(64'h00F0_0F00_F00F_0FF0) + 1, "R9 latency", W'(lat),
              W'($countones(64'h00F0_0F00_F00F_0FF0) + 1));

        // R7 result holds while idle with changing inputs
        @(negedge clk);
        held = result;
        for (int c = 0; c < 6; c++) begin
            mode = c[0]; src = {32'(c), 32'hFFFF_0000}; mask = ~src;
            @(negedge clk);
        end
        check(result == held, "R7 idle hold", result, held);
        check(busy == 1'b0, "R7 stays idle", W'(busy), '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule